// File: doc/BRIEF.md
# Input Undervoltage Lockout Sequencer

This block watches a digitized sample of the input supply and decides whether the power rail it guards may convert. It compares that sample with three thresholds: a start level, a lower level at which an orderly shutdown begins, and a still lower fault level at which a programmable reaction applies. Together these make a two-level lockout. Crossing the middle level requests a soft-stop ramp. Crossing the bottom level raises a sticky fault and either lets the ramp finish, lets it finish and then holds off any restart for a set number of clock cycles, or cuts the switching outputs at once.

The block drives the run and soft-stop requests of an external ramp generator and takes back a ramp-done pulse from it. The immediate-shutdown signal is combinational so that the gate drivers can be blanked in the cycle the fault is seen. A restart after any stop requires the input to have gone to or below the start level and then to rise above it again. The thresholds are expected to be ordered fault < stop < start. The block does not enforce that order.

Top module: `uvlo_sequencer`

## Requirements
- R1: While reset is low and in the first cycle after it is released, run_req, stop_req, kill_now and uv_fault are all 0. The block comes out of reset armed, so a supply that is already above the start level starts the rail.
- R2: When idle and armed, a sample strictly greater than thr_on sets run_req in the next cycle. A sample equal to thr_on does not start the rail.
- R3: While running, a sample strictly below thr_off and not below thr_flt clears run_req and sets stop_req in the next cycle.
- R4: During a soft stop, a ramp_done pulse ends the stop, and stop_req is 0 from the next cycle. When no delayed fault response is pending, the block returns to idle.
- R5: While running or stopping, a sample strictly below thr_flt sets uv_fault in the next cycle. A fault takes priority over the stop condition and over ramp_done.
- R6: Response code 2'b00 (continue): the fault leads to, or keeps, a soft stop, with stop_req 1 until ramp_done.
- R7: Response code 2'b01 (continue with delay): the soft stop finishes, and after ramp_done the block holds for hold_len+1 cycles during which run_req stays 0 whatever the input.
- R8: Response codes 2'b10 and 2'b11 (shut down): kill_now is 1 in the same cycle as the fault sample, and run_req and stop_req are both 0 in the next cycle.
- R9: uv_fault stays 1 until a cycle with fault_clr high and no new fault. A new fault in the same cycle wins over the clear.
- R10: A restart after any stop requires a sample at or below thr_on, taken after leaving the running state, before a sample above thr_on can start the rail again.
- R11: run_req and stop_req are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vin_code | input | VIN_W | Digitized input-supply sample |
| thr_on | input | VIN_W | Start level (strictly above starts) |
| thr_off | input | VIN_W | Soft-stop level (strictly below stops) |
| thr_flt | input | VIN_W | Fault level (strictly below faults) |
| resp_code | input | 2 | Fault reaction: 00 continue, 01 continue with delay, 1x shut down |
| hold_len | input | HOLD_W | Restart hold length in cycles, minus one |
| ramp_done | input | 1 | Pulse from the ramp generator at the end of a soft stop |
| fault_clr | input | 1 | Clears the sticky fault flag |
| run_req | output | 1 | Rail may convert |
| stop_req | output | 1 | Soft-stop ramp requested |
| kill_now | output | 1 | Immediate shutdown, combinational from the fault sample |
| uv_fault | output | 1 | Sticky undervoltage fault flag |

## Verification
The bench places the sample exactly on each threshold. A design that used inclusive comparisons would start on an equal sample or stop one step early. It presents a fault sample in the same cycle as ramp_done and as fault_clr, which catches a design whose priorities are reversed: such a design would drop a delayed hold or lose the fault flag. It times the restart hold against hold_len, so an off-by-one counter shows up as a restart one cycle early or late. It raises the input back above the start level during a soft stop, where a design lacking the re-arm rule would restart at once after ramp_done.

// File: rtl/uvlo_pkg.sv
// Package: shared types for the undervoltage lockout sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package uvlo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_STOP = 2'd2,
        ST_HOLD = 2'd3
    } uvlo_state_e;

    typedef enum logic [1:0] {
        RSP_CONT     = 2'b00,
        RSP_CONT_DLY = 2'b01,
        RSP_KILL     = 2'b10,
        RSP_RSVD     = 2'b11
    } uvlo_resp_e;

    // A response kills the outputs when its upper bit is set (10 and reserved 11).
    function automatic logic resp_is_kill(input logic [1:0] code);
        return code[1];
    endfunction

    function automatic logic resp_is_delay(input logic [1:0] code);
        return code == RSP_CONT_DLY;
    endfunction
endpackage

// File: rtl/uvlo_window.sv
// Module: uvlo_window
// Compares one supply sample against the three lockout levels.
// Assumes: unsigned codes; all comparisons are strict.
module uvlo_window #(
    parameter int VIN_W = 12
) (
    input  logic [VIN_W-1:0] vin_code,
    input  logic [VIN_W-1:0] thr_on,
    input  logic [VIN_W-1:0] thr_off,
    input  logic [VIN_W-1:0] thr_flt,
    output logic             above_on,
    output logic             below_off,
    output logic             below_flt
);
    // Purpose: strict level comparisons.
    always_comb begin
        above_on  = vin_code > thr_on;
        below_off = vin_code < thr_off;
        below_flt = vin_code < thr_flt;
    end
endmodule

// File: rtl/uvlo_hold_timer.sv
// Module: uvlo_hold_timer
// Down-counter for the restart hold. Loaded on entry to the hold state,
// decremented while enabled, flags zero.
// Assumes: load and run are never requested in the same cycle.
module uvlo_hold_timer #(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HOLD_W-1:0] load_val,
    input  logic              run,
    output logic              zero
);
    logic [HOLD_W-1:0] cnt_q;

    // Purpose: load, count down to zero, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Purpose: expose the terminal count.
    always_comb zero = (cnt_q == '0);
endmodule

// File: rtl/uvlo_fsm.sv
// Module: uvlo_fsm
// Sequencing state machine: start, soft stop, fault reaction, restart hold,
// re-arm and sticky fault flag.
// Assumes: comparator flags come from the current sample; the timer is loaded
// on entry to ST_HOLD.
module uvlo_fsm
    import uvlo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       above_on,
    input  logic       below_off,
    input  logic       below_flt,
    input  logic [1:0] resp_code,
    input  logic       ramp_done,
    input  logic       fault_clr,
    input  logic       tmr_zero,
    output logic       tmr_load,
    output logic       tmr_run,
    output logic       run_req,
    output logic       stop_req,
    output logic       kill_now,
    output logic       uv_fault
);
    uvlo_state_e state_q, state_d;
    logic armed_q, armed_d;
    logic dly_q, dly_d;
    logic flt_q, flt_d;
    logic active, flt_hit, dly_pend, leave_run;

    // Purpose: classify the fault sample against the response code.
    always_comb begin
        active   = (state_q == ST_RUN) || (state_q == ST_STOP);
        flt_hit  = active && below_flt;
        kill_now = flt_hit && resp_is_kill(resp_code);
        dly_pend = dly_q || (flt_hit && resp_is_delay(resp_code));
    end

    // Purpose: next-state selection with fault taking priority.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        unique case (state_q)
            ST_IDLE: if (armed_q && above_on) state_d = ST_RUN;
            ST_RUN: begin
                if (kill_now)               state_d = ST_IDLE;
                else if (flt_hit || below_off) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (kill_now) begin
                    state_d = ST_IDLE;
                end else if (ramp_done) begin
                    state_d  = dly_pend ? ST_HOLD : ST_IDLE;
                    tmr_load = dly_pend;
                end
            end
            ST_HOLD: if (tmr_zero) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Purpose: next values of the arm, delay and fault flags.
    always_comb begin
        leave_run = (state_q == ST_RUN) && (state_d != ST_RUN);
        armed_d   = leave_run ? 1'b0 : (armed_q || !above_on);
        dly_d     = (state_d == ST_HOLD || state_d == ST_IDLE) ? 1'b0 : dly_pend;
        if (flt_hit)        flt_d = 1'b1;
        else if (fault_clr) flt_d = 1'b0;
        else                flt_d = flt_q;
    end

    // Purpose: state and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            armed_q <= 1'b1;
            dly_q   <= 1'b0;
            flt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            armed_q <= armed_d;
            dly_q   <= dly_d;
            flt_q   <= flt_d;
        end
    end

    // Purpose: decode the registered outputs.
    always_comb begin
        run_req  = (state_q == ST_RUN);
        stop_req = (state_q == ST_STOP);
        tmr_run  = (state_q == ST_HOLD);
        uv_fault = flt_q;
    end
endmodule

// File: rtl/uvlo_sequencer.sv
// Module: uvlo_sequencer (top)
// Two-level input undervoltage lockout: a start level, a soft-stop level and
// a fault level with a programmable reaction.
// Assumes: thr_flt < thr_off < thr_on; ramp_done comes from the ramp generator.
module uvlo_sequencer #(
    parameter int VIN_W  = 12,
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VIN_W-1:0]  vin_code,
    input  logic [VIN_W-1:0]  thr_on,
    input  logic [VIN_W-1:0]  thr_off,
    input  logic [VIN_W-1:0]  thr_flt,
    input  logic [1:0]        resp_code,
    input  logic [HOLD_W-1:0] hold_len,
    input  logic              ramp_done,
    input  logic              fault_clr,
    output logic              run_req,
    output logic              stop_req,
    output logic              kill_now,
    output logic              uv_fault
);
    logic above_on, below_off, below_flt;
    logic tmr_load, tmr_run, tmr_zero;

    uvlo_window #(.VIN_W(VIN_W)) u_window (
        .vin_code (vin_code),
        .thr_on   (thr_on),
        .thr_off  (thr_off),
        .thr_flt  (thr_flt),
        .above_on (above_on),
        .below_off(below_off),
        .below_flt(below_flt)
    );

    uvlo_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(hold_len),
        .run     (tmr_run),
        .zero    (tmr_zero)
    );

    uvlo_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .above_on (above_on),
        .below_off(below_off),
        .below_flt(below_flt),
        .resp_code(resp_code),
        .ramp_done(ramp_done),
        .fault_clr(fault_clr),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_run  (tmr_run),
        .run_req  (run_req),
        .stop_req (stop_req),
        .kill_now (kill_now),
        .uv_fault (uv_fault)
    );
endmodule

// File: rtl/uvlo_sequencer_chk.sv
// Module: uvlo_sequencer_chk
// Port-level temporal checks for uvlo_sequencer, attached by bind.
// Assumes: synchronous active-low reset.
module uvlo_sequencer_chk #(
    parameter int VIN_W  = 12,
    parameter int HOLD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [VIN_W-1:0]  vin_code,
    input logic [VIN_W-1:0]  thr_off,
    input logic [VIN_W-1:0]  thr_flt,
    input logic [HOLD_W-1:0] hold_len,
    input logic              ramp_done,
    input logic              fault_clr,
    input logic              run_req,
    input logic              stop_req,
    input logic              kill_now,
    input logic              uv_fault
);
    assert_excl_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_req && stop_req));

    assert_kill_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        kill_now |=> (!run_req && !stop_req));

    assert_fault_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_req || stop_req) && vin_code < thr_flt) |=> uv_fault);

    assert_soft_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_req && vin_code < thr_off && vin_code >= thr_flt) |=> (stop_req && !run_req));

    assert_ramp_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && ramp_done && vin_code >= thr_flt) |=> !stop_req);

    assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_fault && !fault_clr) |=> uv_fault);
endmodule

bind uvlo_sequencer uvlo_sequencer_chk #(.VIN_W(VIN_W), .HOLD_W(HOLD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vin_code (vin_code),
    .thr_off  (thr_off),
    .thr_flt  (thr_flt),
    .hold_len (hold_len),
    .ramp_done(ramp_done),
    .fault_clr(fault_clr),
    .run_req  (run_req),
    .stop_req (stop_req),
    .kill_now (kill_now),
    .uv_fault (uv_fault)
);

// File: tb/uvlo_sequencer_bench.sv
// Bench for uvlo_sequencer: directed corner cases, then seeded random walks,
// all compared against a cycle model built from the requirements.
module uvlo_sequencer_bench;
    localparam int VW = 12;
    localparam int HW = 16;
    localparam time CLK_PERIOD = 10ns;
    localparam int WATCHDOG_CYC = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [VW-1:0] vin_code = '0, thr_on = '0, thr_off = '0, thr_flt = '0;
    logic [1:0] resp_code = '0;
    logic [HW-1:0] hold_len = '0;
    logic ramp_done = 1'b0, fault_clr = 1'b0;
    logic run_req, stop_req, kill_now, uv_fault;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // Model state: 0 idle, 1 run, 2 stop, 3 hold.
    int m_st;
    bit m_arm, m_dly, m_flt;
    int m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    uvlo_sequencer #(.VIN_W(VW), .HOLD_W(HW)) u_uvlo_sequencer (
        .clk(clk), .rst_n(rst_n), .vin_code(vin_code), .thr_on(thr_on),
        .thr_off(thr_off), .thr_flt(thr_flt), .resp_code(resp_code),
        .hold_len(hold_len), .ramp_done(ramp_done), .fault_clr(fault_clr),
        .run_req(run_req), .stop_req(stop_req), .kill_now(kill_now),
        .uv_fault(uv_fault)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_kill();
        return (m_st == 1 || m_st == 2) && (vin_code < thr_flt) && resp_code[1];
    endfunction

    // One model cycle from the present inputs (requirement-derived rules).
    task automatic model_step();
        bit act, hit, kill, pend;
        int nx;
        act  = (m_st == 1 || m_st == 2);
        hit  = act && (vin_code < thr_flt);
        kill = hit && resp_code[1];
        pend = m_dly || (hit && resp_code == 2'b01);
        nx = m_st;
        case (m_st)
            0: if (m_arm && vin_code > thr_on) nx = 1;
            1: if (kill) nx = 0; else if (hit || vin_code < thr_off) nx = 2;
            2: if (kill) nx = 0; else if (ramp_done) begin
                   nx = pend ? 3 : 0;
                   if (pend) m_cnt = hold_len;
               end
            default: if (m_cnt == 0) nx = 0; else m_cnt--;
        endcase
        if (m_st == 1 && nx != 1) m_arm = 0;
        else m_arm = m_arm || !(vin_code > thr_on);
        m_dly = (nx == 3 || nx == 0) ? 0 : pend;
        if (hit) m_flt = 1; else if (fault_clr) m_flt = 0;
        m_st = nx;
    endtask

    // Drive at negedge, check the same-cycle kill, clock, check registered outputs.
    task automatic step(input string tag, input int v, input bit rd, input bit clr);
        vin_code = VW'(v); ramp_done = rd; fault_clr = clr;
        #1;
        check({tag, " kill_now (R8)"}, int'(kill_now), int'(exp_kill()));
        model_step();
        @(posedge clk);
        @(negedge clk);
        check({tag, " run_req"},  int'(run_req),  int'(m_st == 1));
        check({tag, " stop_req"}, int'(stop_req), int'(m_st == 2));
        check({tag, " uv_fault"}, int'(uv_fault), int'(m_flt));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ramp_done = 0; fault_clr = 0;
        repeat (3) @(negedge clk);
        check("R1 reset run_req",  int'(run_req), 0);
        check("R1 reset uv_fault", int'(uv_fault), 0);
        rst_n = 1'b1;
        m_st = 0; m_arm = 1; m_dly = 0; m_flt = 0; m_cnt = 0;
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        thr_flt = 12'd200; thr_off = 12'd300; thr_on = 12'd400;
        resp_code = 2'b00; hold_len = 16'd3;
        @(negedge clk);
        do_reset();
        step("R1 first cycle", 100, 0, 0);
        check("R1 stop_req low", int'(stop_req), 0);
        // R2: equal to start level does not start; one above does.
        step("R2 equal", 400, 0, 0);
        check("R2 no start on equal", int'(run_req), 0);
        step("R2 above", 401, 0, 0);
        check("R2 start", int'(run_req), 1);
        // R3: equal to stop level keeps running; one below stops.
        step("R3 equal", 300, 0, 0);
        step("R3 below", 299, 0, 0);
        check("R3 soft stop", int'(stop_req), 1);
        // R10: input back above start during stop; no restart without re-arm.
        step("R10 recover", 500, 0, 0);
        step("R4 ramp done", 500, 1, 0);
        check("R4 idle", int'(stop_req), 0);
        step("R10 no restart", 500, 0, 0);
        check("R10 still idle", int'(run_req), 0);
        step("R10 rearm", 400, 0, 0);
        step("R10 restart", 401, 0, 0);
        check("R10 restart", int'(run_req), 1);
        // R6: continue response, fault during run.
        step("R5 R6 fault", 199, 0, 0);
        check("R6 stop continues", int'(stop_req), 1);
        check("R5 fault set", int'(uv_fault), 1);
        step("R6 hold stop", 150, 0, 0);
        // R9: clear together with new fault sample: fault wins.
        step("R9 clear vs fault", 150, 0, 1);
        check("R9 set wins", int'(uv_fault), 1);
        step("R6 end", 150, 1, 0);
        step("R9 clear", 150, 0, 1);
        check("R9 cleared", int'(uv_fault), 0);
        // R7: delayed response, hold hold_len+1 cycles with input high.
        resp_code = 2'b01;
        step("R7 start", 450, 0, 0);
        step("R7 fault", 100, 0, 0);
        step("R7 ramp done", 100, 1, 0);
        step("R7 hold a", 100, 0, 0);
        for (int i = 0; i < 4; i++) begin
            step("R7 hold", 450, 0, 0);
            if (i < 3) check("R7 no restart in hold", int'(run_req), 0);
        end
        check("R7 restart after hold", int'(run_req), 1);
        // R8: reserved code shuts down in the same cycle.
        resp_code = 2'b11;
        step("R8 kill", 50, 0, 0);
        check("R8 blanked", int'(run_req) + int'(stop_req), 0);

        // Random segments.
        for (int seg = 0; seg < 40; seg++) begin
            int v;
            thr_flt = VW'(100 + $urandom_range(0, 199));
            thr_off = thr_flt + VW'(50 + $urandom_range(0, 199));
            thr_on  = thr_off + VW'(20 + $urandom_range(0, 199));
            resp_code = 2'($urandom_range(0, 3));
            hold_len  = HW'($urandom_range(0, 7));
            if (seg % 10 == 0) do_reset();
            v = int'(thr_on) + 10;
            for (int c = 0; c < 150; c++) begin
                int r = $urandom_range(0, 19);
                if (r == 0)      v = int'(thr_on);
                else if (r == 1) v = int'(thr_off);
                else if (r == 2) v = int'(thr_flt);
                else if (r == 3) v = $urandom_range(0, 1100);
                else v = v + $urandom_range(0, 80) - 40;
                if (v < 0) v = 0;
                if (v > 1100) v = 1100;
                step("R2/R3/R5 random", v, ($urandom_range(0, 5) == 0),
                     ($urandom_range(0, 29) == 0));
            end
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule